// File: doc/BRIEF.md
# PCI Configuration Access Translator

This block sits between a host's I/O port accesses and the PCI configuration machinery. Software first writes a 32-bit address dword to a fixed I/O port. It then reads or writes a four-byte data window. When the enable bit of the stored dword is set, each data-window access becomes one configuration transaction. The block decodes the bus, device, function and register fields to choose where that transaction goes.

On bus zero, device 0 (the bridge itself) and device 1 (the graphics-port function) are served by an internal target. Devices 2 through 20 get a type 0 cycle whose one-hot select line sits at address bit 11 plus the device number. A nonzero bus produces a type 1 cycle that carries the fields unchanged. Devices that have no select line answer reads with all ones and drop writes. Any other port access, and any data-window access while the enable bit is clear, completes at once as ordinary I/O and is flagged as pass-through. Each accepted host request is acknowledged by a single-cycle pulse.

Top module: `cfg_xlate`

## Requirements
- R1: After reset no request or acknowledge is active and the stored address dword reads back as zero.
- R2: A dword write to port 0x0CF8 stores bit 31, bits 23:2 and clears the rest; a dword read there returns the stored value; both acknowledge one cycle after the request with the pass flag low.
- R3: A byte or word access to port 0x0CF8, and any access outside 0x0CF8 and 0x0CFC-0x0CFF, is acknowledged one cycle later with the pass flag high and read data zero; it starts no cycle and leaves the stored dword unchanged.
- R4: A data-window access while bit 31 of the stored dword is clear is acknowledged one cycle later as pass-through and starts no cycle.
- R5: With bus 0 and device 2 to 20, an external type 0 cycle is requested with address bit 11+device set as the only bit among 31:11, function in 10:8, register in 7:2 and bits 1:0 equal to 00.
- R6: With bus field (bits 23:16) nonzero, an external type 1 cycle is requested with address {8'h00, stored bits 23:2, 2'b01}.
- R7: Bus 0 device 0 raises the internal request with the graphics select low, address {21'b0, function, register, 2'b00}; no external request is made and bits 11 and 12 are never set on an external type 0 cycle.
- R8: Bus 0 device 1 raises the internal request with the graphics select high and the same address layout as R7.
- R9: Bus 0 with device 21 to 31 starts no cycle and is acknowledged one cycle later with read data 0xFFFFFFFF.
- R10: Byte enables follow the access size (0 byte, 1 word, 2 dword) and the low two port address bits: byte gives 0001 shifted by the offset, word gives 0011 shifted by the offset and truncated to 4 bits, dword gives 1111.
- R11: A cycle request and its address stay steady until its done input is seen; the acknowledge comes in the cycle after done, lasts one cycle and returns the done cycle's read data on reads; a host request made while busy is ignored.
- R12: The cycle carries the host's write flag and write data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_req | input | 1 | Host access strobe, one cycle |
| io_we | input | 1 | Host access is a write |
| io_addr | input | 16 | Host I/O port address |
| io_size | input | 2 | Access size: 0 byte, 1 word, 2 dword |
| io_wdata | input | 32 | Host write data, lane aligned |
| io_ack | output | 1 | Access complete, one-cycle pulse |
| io_rdata | output | 32 | Read data, valid with io_ack |
| io_pass | output | 1 | Access was ordinary I/O, valid with io_ack |
| ext_req | output | 1 | External configuration cycle request |
| ext_done | input | 1 | External cycle finished |
| ext_rdata | input | 32 | External cycle read data |
| int_req | output | 1 | Internal register target request |
| int_gfx | output | 1 | Internal request targets the graphics function |
| int_done | input | 1 | Internal access finished |
| int_rdata | input | 32 | Internal access read data |
| cfg_type1 | output | 1 | External cycle is type 1 |
| cfg_addr | output | 32 | Configuration cycle address |
| cfg_be | output | 4 | Configuration byte enables |
| cfg_we | output | 1 | Configuration cycle is a write |
| cfg_wdata | output | 32 | Configuration write data |

## Verification
A corrupted stored address dword shows up on the next data-window access as a wrong select bit, a wrong cycle type or a wrongly routed request, and at once on a readback of port 0x0CF8. A sequencer that leaves its busy state early or late shows up as an acknowledge that does not come exactly one cycle after done, or as a request that drops before done. A decode slip at the device boundaries (1/2 and 20/21) shows up as an external cycle where none is allowed or an all-ones read where a cycle was due, in the first cycle after the request.

// File: rtl/cfgx_pkg.sv
package cfgx_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXT,
        ST_INT,
        ST_RESP
    } state_e;

    typedef enum logic [2:0] {
        K_PASS,
        K_ADR_WR,
        K_ADR_RD,
        K_EXT,
        K_INT,
        K_NONE
    } kind_e;

    // Writable bits of the stored address dword: enable, bus, device, function, register
    localparam logic [31:0] ADR_KEEP = 32'h80FF_FFFC;

    typedef struct packed {
        state_e      st;
        logic [31:0] adr;
        logic [31:0] addr;
        logic [3:0]  be;
        logic        we;
        logic        t1;
        logic        gfx;
        logic [31:0] wdata;
        logic [31:0] rdata;
        logic        pass;
    } regs_t;

endpackage

// File: rtl/cfgx_idsel.sv
module cfgx_idsel #(
    parameter int SEL_LSB = 11
) (
    input  logic [4:0]  dev,
    output logic [31:0] line
);
    for (genvar g = 0; g < 32; g++) begin : g_line
        if (g < SEL_LSB) begin : g_low
            assign line[g] = 1'b0;
        end else begin : g_sel
            assign line[g] = (dev == 5'(g - SEL_LSB));
        end
    end
endmodule

// File: rtl/cfgx_be.sv
module cfgx_be (
    input  logic [1:0] off,
    input  logic [1:0] size,
    output logic [3:0] be
);
    always_comb begin
        case (size)
            2'd0:    be = 4'b0001 << off;
            2'd1:    be = 4'b0011 << off;
            default: be = 4'b1111;
        endcase
    end
endmodule

// File: rtl/cfgx_decode.sv
module cfgx_decode
    import cfgx_pkg::*;
#(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] ADR_PORT  = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC,
    parameter int          SEL_LSB   = 11
) (
    input  logic [IO_AW-1:0] io_addr,
    input  logic [1:0]       io_size,
    input  logic             io_we,
    input  logic [31:0]      adr,
    output kind_e            kind,
    output logic [31:0]      addr,
    output logic             t1,
    output logic             gfx
);
    localparam int MAX_DEV = 31 - SEL_LSB;

    logic [7:0]  bus;
    logic [4:0]  dev;
    logic [31:0] sel;
    logic        hit_adr;
    logic        hit_data;

    assign bus      = adr[23:16];
    assign dev      = adr[15:11];
    assign hit_adr  = (io_addr == ADR_PORT[IO_AW-1:0]);
    assign hit_data = (io_addr[IO_AW-1:2] == DATA_PORT[IO_AW-1:2]);

    cfgx_idsel #(.SEL_LSB(SEL_LSB)) u_idsel (
        .dev  (dev),
        .line (sel)
    );

    always_comb begin
        kind = K_PASS;
        t1   = 1'b0;
        gfx  = 1'b0;
        addr = {21'b0, adr[10:2], 2'b00};
        if (hit_adr) begin
            if (io_size == 2'd2) begin
                kind = io_we ? K_ADR_WR : K_ADR_RD;
            end
        end else if (hit_data && adr[31]) begin
            if (bus != 8'd0) begin
                kind = K_EXT;
                t1   = 1'b1;
                addr = {8'h00, adr[23:2], 2'b01};
            end else if (dev == 5'd0) begin
                kind = K_INT;
            end else if (dev == 5'd1) begin
                kind = K_INT;
                gfx  = 1'b1;
            end else if (32'(dev) > MAX_DEV) begin
                kind = K_NONE;
            end else begin
                kind = K_EXT;
                addr = sel | {21'b0, adr[10:2], 2'b00};
            end
        end
    end
endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
    import cfgx_pkg::*;
#(
    parameter int          IO_AW     = 16,
    parameter logic [15:0] ADR_PORT  = 16'h0CF8,
    parameter logic [15:0] DATA_PORT = 16'h0CFC,
    parameter int          SEL_LSB   = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             io_req,
    input  logic             io_we,
    input  logic [IO_AW-1:0] io_addr,
    input  logic [1:0]       io_size,
    input  logic [31:0]      io_wdata,
    output logic             io_ack,
    output logic [31:0]      io_rdata,
    output logic             io_pass,
    output logic             ext_req,
    input  logic             ext_done,
    input  logic [31:0]      ext_rdata,
    output logic             int_req,
    output logic             int_gfx,
    input  logic             int_done,
    input  logic [31:0]      int_rdata,
    output logic             cfg_type1,
    output logic [31:0]      cfg_addr,
    output logic [3:0]       cfg_be,
    output logic             cfg_we,
    output logic [31:0]      cfg_wdata
);
    regs_t       r_d, r_q;
    kind_e       dec_kind;
    logic [31:0] dec_addr;
    logic        dec_t1;
    logic        dec_gfx;
    logic [3:0]  dec_be;

    cfgx_decode #(
        .IO_AW     (IO_AW),
        .ADR_PORT  (ADR_PORT),
        .DATA_PORT (DATA_PORT),
        .SEL_LSB   (SEL_LSB)
    ) u_dec (
        .io_addr (io_addr),
        .io_size (io_size),
        .io_we   (io_we),
        .adr     (r_q.adr),
        .kind    (dec_kind),
        .addr    (dec_addr),
        .t1      (dec_t1),
        .gfx     (dec_gfx)
    );

    cfgx_be u_be (
        .off  (io_addr[1:0]),
        .size (io_size),
        .be   (dec_be)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            ST_IDLE: begin
                if (io_req) begin
                    r_d.st    = ST_RESP;
                    r_d.pass  = 1'b0;
                    r_d.rdata = 32'h0;
                    case (dec_kind)
                        K_ADR_WR: r_d.adr   = io_wdata & ADR_KEEP;
                        K_ADR_RD: r_d.rdata = r_q.adr;
                        K_NONE:   r_d.rdata = 32'hFFFF_FFFF;
                        K_EXT, K_INT: begin
                            r_d.st    = (dec_kind == K_EXT) ? ST_EXT : ST_INT;
                            r_d.addr  = dec_addr;
                            r_d.be    = dec_be;
                            r_d.we    = io_we;
                            r_d.wdata = io_wdata;
                            r_d.t1    = dec_t1;
                            r_d.gfx   = dec_gfx;
                        end
                        default:  r_d.pass  = 1'b1;
                    endcase
                end
            end
            ST_EXT: begin
                if (ext_done) begin
                    r_d.st    = ST_RESP;
                    r_d.rdata = r_q.we ? 32'h0 : ext_rdata;
                end
            end
            ST_INT: begin
                if (int_done) begin
                    r_d.st    = ST_RESP;
                    r_d.rdata = r_q.we ? 32'h0 : int_rdata;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign io_ack    = (r_q.st == ST_RESP);
    assign io_rdata  = r_q.rdata;
    assign io_pass   = r_q.pass;
    assign ext_req   = (r_q.st == ST_EXT);
    assign int_req   = (r_q.st == ST_INT);
    assign int_gfx   = r_q.gfx;
    assign cfg_type1 = r_q.t1;
    assign cfg_addr  = r_q.addr;
    assign cfg_be    = r_q.be;
    assign cfg_we    = r_q.we;
    assign cfg_wdata = r_q.wdata;
endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        io_ack,
    input logic        ext_req,
    input logic        ext_done,
    input logic        int_req,
    input logic        cfg_type1,
    input logic [31:0] cfg_addr,
    input logic [3:0]  cfg_be
);
    // R7
    single_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ext_req && int_req));

    // R7
    no_bridge_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !cfg_type1) |-> (!cfg_addr[11] && !cfg_addr[12]));

    // R5
    type0_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !cfg_type1) |-> (cfg_addr[1:0] == 2'b00 && $countones(cfg_addr[31:11]) == 1));

    // R6
    type1_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && cfg_type1) |-> (cfg_addr[1:0] == 2'b01 && cfg_addr[31:24] == 8'h00));

    // R11
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && !ext_done) |=> (ext_req && $stable(cfg_addr)));

    // R11
    ack_follows_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req && ext_done) |=> io_ack);

    // R11
    ack_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_ack |=> !io_ack);

    // R10
    be_present_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_req || int_req) |-> (cfg_be != 4'b0000));
endmodule

bind cfg_xlate cfg_xlate_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .io_ack    (io_ack),
    .ext_req   (ext_req),
    .ext_done  (ext_done),
    .int_req   (int_req),
    .cfg_type1 (cfg_type1),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be)
);

// File: tb/cfg_xlate_test.sv
module cfg_xlate_test;
    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] adr;
        logic        we;
        logic [1:0]  off;
        logic [1:0]  size;
        logic [1:0]  kind;   // 0 pass, 1 external, 2 internal, 3 no device
        logic        t1;
        logic        gfx;
        logic [31:0] eaddr;
        logic [3:0]  be;
    } vec_t;

    localparam vec_t VECS [0:11] = '{
        '{32'h8000_1000, 1'b0, 2'd0, 2'd2, 2'd1, 1'b0, 1'b0, 32'h0000_2000, 4'hF},
        '{32'h8000_1D10, 1'b0, 2'd2, 2'd0, 2'd1, 1'b0, 1'b0, 32'h0000_4510, 4'h4},
        '{32'h8000_A7FC, 1'b1, 2'd2, 2'd1, 2'd1, 1'b0, 1'b0, 32'h8000_07FC, 4'hC},
        '{32'h8005_4908, 1'b0, 2'd0, 2'd2, 2'd1, 1'b1, 1'b0, 32'h0005_4909, 4'hF},
        '{32'h80FF_FFFC, 1'b0, 2'd0, 2'd1, 2'd1, 1'b1, 1'b0, 32'h00FF_FFFD, 4'h3},
        '{32'h8000_0004, 1'b0, 2'd0, 2'd2, 2'd2, 1'b0, 1'b0, 32'h0000_0004, 4'hF},
        '{32'h8000_0840, 1'b1, 2'd1, 2'd0, 2'd2, 1'b0, 1'b1, 32'h0000_0040, 4'h2},
        '{32'h8000_A800, 1'b0, 2'd0, 2'd2, 2'd3, 1'b0, 1'b0, 32'h0, 4'h0},
        '{32'h8000_F800, 1'b1, 2'd0, 2'd2, 2'd3, 1'b0, 1'b0, 32'h0, 4'h0},
        '{32'h0000_1000, 1'b0, 2'd0, 2'd2, 2'd0, 1'b0, 1'b0, 32'h0, 4'h0},
        '{32'h8000_1000, 1'b0, 2'd3, 2'd0, 2'd1, 1'b0, 1'b0, 32'h0000_2000, 4'h8},
        '{32'h8000_1000, 1'b0, 2'd1, 2'd1, 2'd1, 1'b0, 1'b0, 32'h0000_2000, 4'h6}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_req = 1'b0;
    logic        io_we = 1'b0;
    logic [15:0] io_addr = 16'h0;
    logic [1:0]  io_size = 2'd0;
    logic [31:0] io_wdata = 32'h0;
    logic        io_ack;
    logic [31:0] io_rdata;
    logic        io_pass;
    logic        ext_req;
    logic        ext_done = 1'b0;
    logic [31:0] ext_rdata = 32'h0;
    logic        int_req;
    logic        int_gfx;
    logic        int_done = 1'b0;
    logic [31:0] int_rdata = 32'h0;
    logic        cfg_type1;
    logic [31:0] cfg_addr;
    logic [3:0]  cfg_be;
    logic        cfg_we;
    logic [31:0] cfg_wdata;

    int unsigned n_chk = 0;
    int unsigned n_bad = 0;
    logic        ended = 1'b0;

    // observations of the last transaction
    int          o_seen;
    int          o_lat;
    logic [31:0] o_addr, o_wdata, o_rdata;
    logic [3:0]  o_be;
    logic        o_t1, o_gfx, o_we, o_pass, o_hold, o_ackok, o_acked;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfg_xlate uut (
        .clk (clk), .rst_n (rst_n),
        .io_req (io_req), .io_we (io_we), .io_addr (io_addr), .io_size (io_size),
        .io_wdata (io_wdata), .io_ack (io_ack), .io_rdata (io_rdata), .io_pass (io_pass),
        .ext_req (ext_req), .ext_done (ext_done), .ext_rdata (ext_rdata),
        .int_req (int_req), .int_gfx (int_gfx), .int_done (int_done), .int_rdata (int_rdata),
        .cfg_type1 (cfg_type1), .cfg_addr (cfg_addr), .cfg_be (cfg_be),
        .cfg_we (cfg_we), .cfg_wdata (cfg_wdata)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic xact(input logic we, input logic [15:0] a, input logic [1:0] sz,
                        input logic [31:0] wd, input logic [31:0] resp);
        @(negedge clk);
        io_req = 1'b1; io_we = we; io_addr = a; io_size = sz; io_wdata = wd;
        @(negedge clk);
        io_req = 1'b0;
        o_seen = 0; o_lat = 1; o_hold = 1'b1; o_ackok = 1'b1; o_acked = 1'b0;
        o_rdata = 32'hx; o_pass = 1'bx;
        for (int n = 0; n < 20; n++) begin
            if (io_ack) begin
                o_rdata = io_rdata; o_pass = io_pass; o_acked = 1'b1;
                break;
            end else if (ext_req || int_req) begin
                o_seen = ext_req ? 1 : 2;
                o_addr = cfg_addr; o_be = cfg_be; o_t1 = cfg_type1; o_gfx = int_gfx;
                o_we = cfg_we; o_wdata = cfg_wdata;
                @(negedge clk);
                if (!(ext_req || int_req) || cfg_addr !== o_addr) o_hold = 1'b0;
                if (o_seen == 1) begin ext_done = 1'b1; ext_rdata = resp; end
                else begin int_done = 1'b1; int_rdata = resp; end
                @(negedge clk);
                ext_done = 1'b0; int_done = 1'b0;
                o_ackok = io_ack;
            end else begin
                @(negedge clk);
                o_lat++;
            end
        end
    endtask

    task automatic put_adr(input logic [31:0] v);
        xact(1'b1, 16'h0CF8, 2'd2, v, 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 ack", {31'b0, io_ack}, 32'h0);
        check("R1 req", {30'b0, ext_req, int_req}, 32'h0);
        rst_n = 1'b1;
        xact(1'b0, 16'h0CF8, 2'd2, 32'h0, 32'h0);
        check("R1 stored dword", o_rdata, 32'h0);

        // table walk
        for (int i = 0; i < 12; i++) begin
            logic [31:0] resp;
            logic [31:0] wd;
            vec_t v;
            v = VECS[i];
            resp = 32'hC0DE_0000 | i;
            wd = 32'h5A5A_0000 | i;
            put_adr(v.adr);
            xact(v.we, 16'h0CFC + {14'b0, v.off}, v.size, wd, resp);
            case (v.kind)
                2'd0: begin
                    check("R4 no cycle", o_seen, 0);
                    check("R4 pass flag", {31'b0, o_pass}, 32'h1);
                    check("R4 latency", o_lat, 1);
                end
                2'd3: begin
                    check("R9 no cycle", o_seen, 0);
                    check("R9 pass flag", {31'b0, o_pass}, 32'h0);
                    check("R9 latency", o_lat, 1);
                    if (!v.we) check("R9 all ones", o_rdata, 32'hFFFF_FFFF);
                end
                default: begin
                    if (v.kind == 2'd2) begin
                        check(v.gfx ? "R8 internal" : "R7 internal", o_seen, 2);
                        check(v.gfx ? "R8 gfx select" : "R7 gfx select", {31'b0, o_gfx}, {31'b0, v.gfx});
                        check("R7 address", o_addr, v.eaddr);
                    end else if (v.t1) begin
                        check("R6 external", o_seen, 1);
                        check("R6 type", {31'b0, o_t1}, 32'h1);
                        check("R6 address", o_addr, v.eaddr);
                    end else begin
                        check("R5 external", o_seen, 1);
                        check("R5 type", {31'b0, o_t1}, 32'h0);
                        check("R5 address", o_addr, v.eaddr);
                    end
                    check("R10 byte enables", {28'b0, o_be}, {28'b0, v.be});
                    check("R11 request held", {31'b0, o_hold}, 32'h1);
                    check("R11 ack after done", {31'b0, o_ackok}, 32'h1);
                    check("R12 write flag", {31'b0, o_we}, {31'b0, v.we});
                    if (v.we) check("R12 write data", o_wdata, wd);
                    else check("R11 read data", o_rdata, resp);
                end
            endcase
        end

        // R2: reserved bits drop on store
        put_adr(32'hFFFF_FFFF);
        check("R2 write ack", {31'b0, o_pass}, 32'h0);
        xact(1'b0, 16'h0CF8, 2'd2, 32'h0, 32'h0);
        check("R2 readback", o_rdata, 32'h80FF_FFFC);
        check("R2 latency", o_lat, 1);

        // R3: byte write to address port is plain I/O and does not alter the dword
        xact(1'b1, 16'h0CF8, 2'd0, 32'h0, 32'h0);
        check("R3 pass flag", {31'b0, o_pass}, 32'h1);
        check("R3 no cycle", o_seen, 0);
        xact(1'b0, 16'h0CF8, 2'd2, 32'h0, 32'h0);
        check("R3 dword kept", o_rdata, 32'h80FF_FFFC);
        xact(1'b0, 16'h0080, 2'd2, 32'h0, 32'h0);
        check("R3 other port pass", {31'b0, o_pass}, 32'h1);
        check("R3 other port data", o_rdata, 32'h0);

        // R11: request while busy is ignored
        put_adr(32'h8000_1800);
        @(negedge clk);
        io_req = 1'b1; io_we = 1'b0; io_addr = 16'h0CFC; io_size = 2'd2;
        @(negedge clk);
        io_we = 1'b1; io_addr = 16'h0CF8; io_wdata = 32'h0;
        check("R11 busy external", {31'b0, ext_req}, 32'h1);
        @(negedge clk);
        io_req = 1'b0;
        check("R11 still busy", {31'b0, ext_req}, 32'h1);
        ext_done = 1'b1; ext_rdata = 32'h1234_5678;
        @(negedge clk);
        ext_done = 1'b0;
        check("R11 ack", {31'b0, io_ack}, 32'h1);
        check("R11 busy read data", io_rdata, 32'h1234_5678);
        @(negedge clk);
        check("R11 ack one cycle", {31'b0, io_ack}, 32'h0);
        xact(1'b0, 16'h0CF8, 2'd2, 32'h0, 32'h0);
        check("R11 dword untouched", o_rdata, 32'h8000_1800);

        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        end
        $finish;
    end
endmodule